// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that finishes one instruction per clock for a small load/store instruction set: word load and word store, add, subtract, bitwise AND and OR, signed set-less-than, branch when two registers are equal, and an unconditional jump. Every instruction is fetched, decoded, executed and written back in the same cycle. The core holds the program counter, a 32-entry register file with two read ports and one write port, a main decoder, a two-level ALU control, the ALU, and the next-address logic for branches and jumps. Instruction and data memories are small internal word arrays.

The memories are filled through a load stream (`ld_valid`/`ld_ready`, with `ld_sel` choosing the instruction array when 0 and the data array when 1). The core accepts that stream only while reset is held, so `ld_ready` equals `rst`. A beat moves on a rising edge where `ld_valid` and `ld_ready` are both high. Once reset is released, every instruction leaves on a retire stream (`ret_valid`/`ret_ready`). `ret_valid` is high in every cycle out of reset, and the fields describe the instruction at the current program counter. That instruction commits, and all of its state changes happen, on the rising edge where `ret_ready` is high. With `ret_ready` low the core holds all of its state, and the retire fields stay unchanged.

The ALU control has two levels. The main decoder gives a 2-bit class: 00 for memory access, 01 for branch and 10 for register-register. The ALU control uses that class, together with the 6-bit function field for class 10, to choose a 3-bit ALU operation. The top bit of that operation inverts the second operand and adds a carry-in of one.

Top module: `scc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. During reset, `ld_ready` is 1 and `ret_valid` is 0, and `ret_pc` is 0 in the first cycle after reset. Out of reset, `ld_ready` is 0.
- R2: Out of reset, `ret_valid` is 1. While `ret_ready` is 0, the program counter, registers and data memory hold, and `ret_pc` stays constant.
- R3: The opcode is bits 31-26, and opcode 000000 is register-register, with rs in bits 25-21, rt in 20-16 and rd in 15-11. The funct field (bits 5-0) selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR. The result is written to rd. The ALU operation codes are 010 add, 110 subtract, 000 AND, 001 OR and 111 set-less-than.
- R4: Funct 101010 writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R5: Opcode 100011 (load word) writes to rt the data word at byte address rs + sign-extended bits 15-0. Load and store use ALU class 00, which forces an add.
- R6: Opcode 101011 (store word) writes rt to the data word at rs + sign-extended bits 15-0. It reports `ret_mem_we`=1 and does not write a register.
- R7: Opcode 000100 compares rs with rt by subtraction. When they are equal, the next PC is PC+4 + (sign-extended bits 15-0 shifted left by 2). Otherwise it is PC+4. The branch writes nothing.
- R8: Opcode 000010 jumps to {(PC+4)[31:28], bits 25-0, 00} and writes nothing.
- R9: Register 0 always reads as 0. A write to it is discarded, and the retire port reports `ret_rf_we`=0 for it.
- R10: Any other opcode writes neither a register nor memory, and continues at PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Load stream beat valid |
| ld_ready | output | 1 | Load stream ready (high only in reset) |
| ld_sel | input | 1 | 0 = instruction array, 1 = data array |
| ld_addr | input | MEM_AW | Word index for the load beat |
| ld_data | input | 32 | Word to store |
| ret_valid | output | 1 | Retire record valid (high out of reset) |
| ret_ready | input | 1 | Retire accepted; the instruction commits at this edge |
| ret_pc | output | 32 | Address of the retiring instruction |
| ret_rf_we | output | 1 | Instruction writes a nonzero register |
| ret_rd | output | 5 | Destination register index |
| ret_wdata | output | 32 | Value written to the register |
| ret_mem_we | output | 1 | Instruction writes data memory |
| ret_maddr | output | 32 | ALU result (byte address for load and store) |
| ret_mdata | output | 32 | rt value (store data) |

## Verification
A wrong register or memory word stays hidden until an instruction reads it. It then shows as a wrong `ret_wdata` or `ret_mdata` on that instruction's retire record, in the same cycle. The test program therefore reads back each value it writes, including register 0 and a stored word. A wrong program counter shows at once as an unexpected `ret_pc` on the next record. Holding `ret_ready` low exposes any state that moves during a stall: the record would change while it is being held.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int XW = 32;

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_REG = 2'b10
  } alu_class_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic       reg_write;
    logic       dst_rd;
    logic       src_imm;
    logic       mem_write;
    logic       load;
    logic       branch;
    logic       jump;
    alu_class_e cls;
  } ctrl_t;
endpackage

// File: rtl/scc_decoder.sv
module scc_decoder
  import scc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.cls = CLS_MEM;
    case (opcode)
      OP_REG: begin
        ctl.reg_write = 1'b1;
        ctl.dst_rd    = 1'b1;
        ctl.cls       = CLS_REG;
      end
      OP_LOAD: begin
        ctl.reg_write = 1'b1;
        ctl.src_imm   = 1'b1;
        ctl.load      = 1'b1;
      end
      OP_STOR: begin
        ctl.src_imm   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.cls    = CLS_BR;
      end
      OP_JMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/scc_aluctl.sv
module scc_aluctl
  import scc_pkg::*;
(
  input  alu_class_e cls,
  input  logic [5:0] funct,
  output alu_op_e    op
);
  always_comb begin
    case (cls)
      CLS_BR:  op = ALU_SUB;
      CLS_REG: begin
        case (funct)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import scc_pkg::*;
#(
  parameter int W = XW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic         negate;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         less;

  assign negate = op[2];
  assign b_eff  = negate ? ~b : b;
  assign sum    = a + b_eff + {{(W-1){1'b0}}, negate};
  // signed compare: differing signs decide directly, else the difference sign
  assign less   = (a[W-1] ^ b[W-1]) ? a[W-1] : sum[W-1];

  always_comb begin
    case (op[1:0])
      2'b00:   y = a & b;
      2'b01:   y = a | b;
      2'b10:   y = sum;
      default: y = {{(W-1){1'b0}}, less};
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_pkg::*;
#(
  parameter int N_REGS = 32,
  parameter int W      = XW,
  localparam int AW    = $clog2(N_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] cells [N_REGS];

  assign cells[0] = '0;

  for (genvar g = 1; g < N_REGS; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)                           cells[g] <= '0;
      else if (we && waddr == AW'(g))    cells[g] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int N_REGS = 32,
  localparam int RAW   = $clog2(N_REGS),
  localparam int WORDS = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_sel,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XW-1:0]     ld_data,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [XW-1:0]     ret_pc,
  output logic              ret_rf_we,
  output logic [RAW-1:0]    ret_rd,
  output logic [XW-1:0]     ret_wdata,
  output logic              ret_mem_we,
  output logic [XW-1:0]     ret_maddr,
  output logic [XW-1:0]     ret_mdata
);
  logic [XW-1:0] pc, pc_plus4, pc_next, br_target, jmp_target;
  logic [XW-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, load_val, wb_val;
  logic [XW-1:0] imem [WORDS];
  logic [XW-1:0] dmem [WORDS];
  logic [RAW-1:0] wb_idx;
  logic           fire, alu_zero, take_branch;
  ctrl_t          ctl;
  alu_op_e        alu_op;

  assign ld_ready  = rst;
  assign ret_valid = ~rst;
  assign fire      = ret_valid & ret_ready;

  // instruction fetch and memory loading
  always_ff @(posedge clk) begin
    if (rst && ld_valid && !ld_sel) imem[ld_addr] <= ld_data;
  end
  assign instr = imem[pc[MEM_AW+1:2]];

  scc_decoder u_dec (.opcode(instr[31:26]), .ctl(ctl));

  scc_aluctl u_actl (.cls(ctl.cls), .funct(instr[5:0]), .op(alu_op));

  assign wb_idx = ctl.dst_rd ? instr[15:11] : instr[20:16];

  scc_regfile #(.N_REGS(N_REGS), .W(XW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl.reg_write & fire),
    .waddr   (wb_idx),
    .wdata   (wb_val),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign imm_ext = {{(XW-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctl.src_imm ? imm_ext : rt_val;

  scc_alu #(.W(XW)) u_alu (
    .a(rs_val), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero)
  );

  // data memory
  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_valid && ld_sel) dmem[ld_addr] <= ld_data;
    end else if (fire && ctl.mem_write) begin
      dmem[alu_y[MEM_AW+1:2]] <= rt_val;
    end
  end
  assign load_val = dmem[alu_y[MEM_AW+1:2]];
  assign wb_val   = ctl.load ? load_val : alu_y;

  // next address
  assign pc_plus4    = pc + 32'd4;
  assign br_target   = pc_plus4 + {imm_ext[XW-3:0], 2'b00};
  assign jmp_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_branch = ctl.branch & alu_zero;
  assign pc_next     = ctl.jump ? jmp_target : (take_branch ? br_target : pc_plus4);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (fire) pc <= pc_next;
  end

  assign ret_pc     = pc;
  assign ret_rf_we  = ctl.reg_write && (wb_idx != '0);
  assign ret_rd     = wb_idx;
  assign ret_wdata  = wb_val;
  assign ret_mem_we = ctl.mem_write;
  assign ret_maddr  = alu_y;
  assign ret_mdata  = rt_val;

  // checks on the control and next-address paths
  assert_pc_zero_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (pc == '0));

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (rst)
    !ret_ready |=> $stable(pc));

  assert_mem_class_add_R5: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_LOAD || instr[31:26] == OP_STOR) |-> (alu_op == ALU_ADD));

  assert_branch_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && instr[31:26] == OP_BEQ && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4));

  assert_jump_field_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && instr[31:26] == OP_JMP) |=> (pc[27:2] == $past(instr[25:0]) && pc[1:0] == 2'b00));

  assert_unknown_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != OP_REG && instr[31:26] != OP_LOAD && instr[31:26] != OP_STOR &&
     instr[31:26] != OP_BEQ && instr[31:26] != OP_JMP) |-> (!ret_rf_we && !ret_mem_we));
endmodule

// File: tb/sim_scc_core.sv
module sim_scc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0, ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        ret_ready = 1'b1;
  logic        ld_ready, ret_valid, ret_rf_we, ret_mem_we;
  logic [4:0]  ret_rd;
  logic [31:0] ret_pc, ret_wdata, ret_maddr, ret_mdata;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  typedef struct {
    logic [31:0] pc;
    bit          rfwe;
    logic [4:0]  rd;
    logic [31:0] wd;
    bit          mwe;
    logic [31:0] ma;
    logic [31:0] md;
    string       req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  scc_core u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_pc(ret_pc), .ret_rf_we(ret_rf_we), .ret_rd(ret_rd), .ret_wdata(ret_wdata),
    .ret_mem_we(ret_mem_we), .ret_maddr(ret_maddr), .ret_mdata(ret_mdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic load(input bit sel, input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
  endtask

  task automatic expect_ret(input logic [31:0] pc, input bit rfwe, input int rd,
                            input logic [31:0] wd, input bit mwe, input logic [31:0] ma,
                            input logic [31:0] md, input string req);
    exp_t e;
    e.pc = pc; e.rfwe = rfwe; e.rd = 5'(rd); e.wd = wd;
    e.mwe = mwe; e.ma = ma; e.md = md; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares each accepted retire record with the scoreboard front
  always @(negedge clk) begin
    if (running && ret_valid && ret_ready && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(ret_pc == e.pc, e.req, "pc", ret_pc, e.pc);
      check(ret_rf_we == e.rfwe, e.req, "rf_we", 32'(ret_rf_we), 32'(e.rfwe));
      if (e.rfwe) begin
        check(ret_rd == e.rd, e.req, "rd", 32'(ret_rd), 32'(e.rd));
        check(ret_wdata == e.wd, e.req, "wdata", ret_wdata, e.wd);
      end
      check(ret_mem_we == e.mwe, e.req, "mem_we", 32'(ret_mem_we), 32'(e.mwe));
      if (e.mwe) begin
        check(ret_maddr == e.ma, e.req, "maddr", ret_maddr, e.ma);
        check(ret_mdata == e.md, e.req, "mdata", ret_mdata, e.md);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired with %0d records pending", q.size());
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [31:0] held_pc;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(ld_ready == 1'b1, "R1", "ld_ready in reset", 32'(ld_ready), 32'd1);
    check(ret_valid == 1'b0, "R1", "ret_valid in reset", 32'(ret_valid), 32'd0);

    // data words
    load(1'b1, 6'd0, 32'h0000_0011);
    load(1'b1, 6'd1, 32'hFFFF_FFF0);
    load(1'b1, 6'd2, 32'h0000_0007);
    // program (word index = byte address / 4)
    load(1'b0, 6'h00, enc_i(6'b100011, 0, 1, 16'd0));       // lw r1,0(r0)
    load(1'b0, 6'h01, enc_i(6'b100011, 0, 2, 16'd4));       // lw r2,4(r0)
    load(1'b0, 6'h02, enc_r(1, 2, 3, 6'b100000));           // add r3
    load(1'b0, 6'h03, enc_r(1, 2, 4, 6'b100010));           // sub r4
    load(1'b0, 6'h04, enc_r(1, 2, 5, 6'b100100));           // and r5
    load(1'b0, 6'h05, enc_r(1, 2, 6, 6'b100101));           // or r6
    load(1'b0, 6'h06, enc_r(2, 1, 7, 6'b101010));           // slt r7 = (-16 < 17)
    load(1'b0, 6'h07, enc_r(1, 2, 8, 6'b101010));           // slt r8 = (17 < -16)
    load(1'b0, 6'h08, enc_r(1, 1, 0, 6'b100000));           // add r0 (discarded)
    load(1'b0, 6'h09, enc_r(0, 1, 9, 6'b100000));           // add r9 = r0 + r1
    load(1'b0, 6'h0A, enc_i(6'b101011, 0, 6, 16'd8));       // sw r6,8(r0)
    load(1'b0, 6'h0B, enc_i(6'b100011, 0, 10, 16'd8));      // lw r10,8(r0)
    load(1'b0, 6'h0C, enc_i(6'b000100, 1, 2, 16'd5));       // beq not taken
    load(1'b0, 6'h0D, enc_i(6'b000100, 1, 9, 16'd2));       // beq taken -> 0x40
    load(1'b0, 6'h0E, enc_r(1, 1, 11, 6'b100000));          // skipped
    load(1'b0, 6'h10, {6'h3F, 26'd0});                      // unknown opcode
    load(1'b0, 6'h11, {6'b000010, 26'h14});                 // j 0x50
    load(1'b0, 6'h12, enc_r(1, 1, 13, 6'b100000));          // skipped
    load(1'b0, 6'h14, enc_r(3, 3, 12, 6'b100000));          // add r12 = 2
    load(1'b0, 6'h15, enc_i(6'b000100, 0, 0, 16'hFFFE));    // beq back to 0x50
    @(posedge clk); #1;
    ld_valid = 1'b0;

    expect_ret(32'h00, 1, 1, 32'h11, 0, 0, 0, "R5");
    expect_ret(32'h04, 1, 2, 32'hFFFF_FFF0, 0, 0, 0, "R5");
    expect_ret(32'h08, 1, 3, 32'h1, 0, 0, 0, "R3");
    expect_ret(32'h0C, 1, 4, 32'h21, 0, 0, 0, "R3");
    expect_ret(32'h10, 1, 5, 32'h10, 0, 0, 0, "R3");
    expect_ret(32'h14, 1, 6, 32'hFFFF_FFF1, 0, 0, 0, "R3");
    expect_ret(32'h18, 1, 7, 32'h1, 0, 0, 0, "R4");
    expect_ret(32'h1C, 1, 8, 32'h0, 0, 0, 0, "R4");
    expect_ret(32'h20, 0, 0, 0, 0, 0, 0, "R9");
    expect_ret(32'h24, 1, 9, 32'h11, 0, 0, 0, "R9");
    expect_ret(32'h28, 0, 0, 0, 1, 32'h8, 32'hFFFF_FFF1, "R6");
    expect_ret(32'h2C, 1, 10, 32'hFFFF_FFF1, 0, 0, 0, "R6");
    expect_ret(32'h30, 0, 0, 0, 0, 0, 0, "R7");
    expect_ret(32'h34, 0, 0, 0, 0, 0, 0, "R7");
    expect_ret(32'h40, 0, 0, 0, 0, 0, 0, "R10");
    expect_ret(32'h44, 0, 0, 0, 0, 0, 0, "R8");
    expect_ret(32'h50, 1, 12, 32'h2, 0, 0, 0, "R8");
    expect_ret(32'h54, 0, 0, 0, 0, 0, 0, "R7");
    expect_ret(32'h50, 1, 12, 32'h2, 0, 0, 0, "R7");

    rst = 1'b0;
    running = 1'b1;
    @(negedge clk);
    check(ret_pc == 32'h0, "R1", "pc after reset", ret_pc, 32'h0);
    check(ld_ready == 1'b0, "R1", "ld_ready out of reset", 32'(ld_ready), 32'd0);
    check(ret_valid == 1'b1, "R2", "ret_valid out of reset", 32'(ret_valid), 32'd1);

    // stall for three cycles in the middle of the program
    repeat (3) @(posedge clk);
    #1 ret_ready = 1'b0;
    @(negedge clk);
    held_pc = ret_pc;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ret_pc == held_pc, "R2", "pc held in stall", ret_pc, held_pc);
      check(ret_valid == 1'b1, "R2", "valid held in stall", 32'(ret_valid), 32'd1);
    end
    @(posedge clk); #1 ret_ready = 1'b1;

    wait (q.size() == 0);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule